// File: doc/BRIEF.md
# Leading-Stream Recovery Sequencer

In a paired-core arrangement, one core runs a shortened, speculative copy of a program (the leading stream) and a second core runs the full program (the trailing stream) and checks the first. When the trailing core finds that a value or branch outcome supplied by the leading core was wrong, the leading core's state is no longer trustworthy. This block repairs it. While the leading core runs normally, the block notes every memory address its stores touch. When recovery is triggered, the block steps through a fixed sequence of repair strobes. First the buffer between the cores is emptied. Then the leading program counter is reloaded and the removal predictor is rewound to the same precise PC. Next every architectural register is copied from the trailing context. Finally every memory word that the leading core may have altered is restored.

Each step appears as a one-cycle strobe, or as a run of strobes that carries an index or address. Surrounding logic moves the actual data. The address table is small. If more distinct addresses are stored than it can hold, the block stops trusting the table and restores the whole memory range instead. After a pass completes, the table is emptied so that tracking starts again from the repaired state.

Top module: `slip_recovery`

## Requirements
- R1: After reset, `busy`, `done` and all step strobes (`dbFlush`, `pcLoad`, `predBackup`, `regCopy`, `memRestore`) are 0.
- R2: A `mismatch` sampled high while idle is followed, on the next three cycles, by `dbFlush`, then `pcLoad`, then `predBackup`, each high for exactly one cycle. `pcValue` equals the `trailPc` that was sampled with the trigger during both `pcLoad` and `predBackup`.
- R3: Right after `predBackup`, `regCopy` is high for 32 consecutive cycles, with `regIdx` counting 0 to 31 in ascending order.
- R4: After the register phase, `memRestore` is high for one cycle per tracked address, with `memAddr` giving the addresses in the order they were first recorded.
- R5: A store (`storeValid` high while idle) to an address already in the table does not add an entry.
- R6: If no address is tracked, there is no `memRestore` cycle, and `done` comes in the cycle after `regIdx` 31.
- R7: The table holds 16 distinct addresses. A store of a 17th distinct address sets a sticky overflow. While overflow is set, the memory phase visits every address from 0 to 255 in ascending order.
- R8: `done` is high for one cycle, right after the last step. `busy` is high from the first step through the `done` cycle and low in the cycle after it. At most one of the six strobes is high in any cycle.
- R9: Completing a pass empties the table and clears overflow, so a later recovery with no new stores has no memory phase.
- R10: A `mismatch` that arrives while `busy` is high is ignored. It does not restart, lengthen or repeat the sequence, and no flush follows `done`.
- R11: A store sampled in the same cycle as the trigger is recorded and restored. Stores sampled while `busy` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| storeValid | input | 1 | Leading-stream store retires this cycle |
| storeAddr | input | 8 | Word address of that store |
| mismatch | input | 1 | Trailing stream reports a deviation |
| trailPc | input | 32 | Precise PC of the trailing stream |
| busy | output | 1 | Recovery sequence in progress |
| dbFlush | output | 1 | Empty the inter-core buffer |
| pcLoad | output | 1 | Reload the leading PC from `pcValue` |
| predBackup | output | 1 | Rewind the removal predictor to `pcValue` |
| pcValue | output | 32 | PC captured at the trigger |
| regCopy | output | 1 | Copy register `regIdx` from the trailing context |
| regIdx | output | 5 | Register being copied |
| memRestore | output | 1 | Restore memory word `memAddr` |
| memAddr | output | 8 | Memory word being restored |
| done | output | 1 | Recovery complete |

## Verification
Two functions can fall in the same cycle: recording a store, and accepting a trigger. The bench provokes this by presenting a store of a fresh address together with `mismatch`. It judges the result by whether that address appears as the last `memRestore` of the pass that follows. A related overlap occurs during recovery, when the bench keeps driving random stores and repeated triggers on most cycles. In that case the exact expected strobe sequence must still appear cycle for cycle, with no extra memory steps and no second flush after `done`.

// File: rtl/rc_pkg.sv
package rc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FLUSH,
    ST_PC,
    ST_PRED,
    ST_REGS,
    ST_MEM,
    ST_DONE
  } phase_t;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic recordEn;    // accept store addresses into the table
    logic capture;     // latch trailPc at the trigger
    logic idxClear;    // reset the step index
    logic idxStep;     // advance the step index
    logic tableClear;  // empty the table and drop overflow
  } dpStrobe_t;

endpackage

// File: rtl/rc_datapath.sv
module rc_datapath
  import rc_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int PC_W        = 32,
  parameter int NUM_REGS    = 32,
  parameter int TABLE_DEPTH = 16
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  dpStrobe_t                   strobe,
  input  logic                        storeValid,
  input  logic [ADDR_W-1:0]           storeAddr,
  input  logic [PC_W-1:0]             trailPc,
  output logic [PC_W-1:0]             pcHeld,
  output logic [$clog2(NUM_REGS)-1:0] regIdx,
  output logic [ADDR_W-1:0]           memAddr,
  output logic                        regLast,
  output logic                        memLast,
  output logic                        memNone
);

  localparam int MEM_WORDS = 1 << ADDR_W;
  localparam int TBL_W     = $clog2(TABLE_DEPTH);
  localparam int CNT_W     = TBL_W + 1;
  localparam int SPAN      = (NUM_REGS > MEM_WORDS) ? NUM_REGS : MEM_WORDS;
  localparam int IDX_W     = $clog2(SPAN) + 1;
  localparam int REG_W     = $clog2(NUM_REGS);

  logic [ADDR_W-1:0]      entry [TABLE_DEPTH];
  logic [CNT_W-1:0]       fillCount;
  logic                   overflow;
  logic [IDX_W-1:0]       stepIdx;
  logic [TABLE_DEPTH-1:0] hitVec;
  logic                   anyHit;
  logic                   tableFull;
  logic                   recordNew;

  // Duplicate detection across the filled part of the table
  for (genvar i = 0; i < TABLE_DEPTH; i++) begin : gHit
    assign hitVec[i] = (CNT_W'(i) < fillCount) && (entry[i] == storeAddr);
  end

  assign anyHit    = |hitVec;
  assign tableFull = (fillCount == CNT_W'(TABLE_DEPTH));
  assign recordNew = strobe.recordEn && storeValid && !anyHit;

  for (genvar i = 0; i < TABLE_DEPTH; i++) begin : gEntry
    always_ff @(posedge clk) begin
      if (!rstN) begin
        entry[i] <= '0;
      end else if (recordNew && fillCount == CNT_W'(i)) begin
        entry[i] <= storeAddr;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fillCount <= '0;
      overflow  <= 1'b0;
    end else if (strobe.tableClear) begin
      fillCount <= '0;
      overflow  <= 1'b0;
    end else if (recordNew) begin
      if (tableFull) overflow <= 1'b1;
      else           fillCount <= fillCount + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcHeld <= '0;
    end else if (strobe.capture) begin
      pcHeld <= trailPc;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stepIdx <= '0;
    end else if (strobe.idxClear) begin
      stepIdx <= '0;
    end else if (strobe.idxStep) begin
      stepIdx <= stepIdx + 1'b1;
    end
  end

  assign regIdx  = stepIdx[REG_W-1:0];
  assign regLast = (stepIdx == IDX_W'(NUM_REGS - 1));
  assign memNone = !overflow && (fillCount == '0);
  assign memAddr = overflow ? stepIdx[ADDR_W-1:0] : entry[stepIdx[TBL_W-1:0]];

  always_comb begin
    if (overflow) memLast = (stepIdx == IDX_W'(MEM_WORDS - 1));
    else          memLast = (stepIdx == (IDX_W'(fillCount) - 1'b1));
  end

  // R7: table never grows past its depth; overflow stays until a clear
  a_r7_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    fillCount <= CNT_W'(TABLE_DEPTH));

  a_r7_sticky_overflow: assert property (@(posedge clk) disable iff (!rstN)
    overflow && !strobe.tableClear |=> overflow);

  // R5: a repeated address leaves the fill level unchanged
  a_r5_dup_no_grow: assert property (@(posedge clk) disable iff (!rstN)
    strobe.recordEn && storeValid && anyHit && !strobe.tableClear |=> $stable(fillCount));

  // R9: a clear leaves an empty, non-overflowed table
  a_r9_cleared: assert property (@(posedge clk) disable iff (!rstN)
    strobe.tableClear |=> (fillCount == '0) && !overflow);

  // R11: while recording is off, the table does not change
  a_r11_frozen: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.recordEn && !strobe.tableClear |=> $stable(fillCount) && $stable(overflow));

endmodule

// File: rtl/rc_ctrl.sv
module rc_ctrl
  import rc_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      mismatch,
  input  logic      regLast,
  input  logic      memLast,
  input  logic      memNone,
  output dpStrobe_t strobe,
  output logic      busy,
  output logic      dbFlush,
  output logic      pcLoad,
  output logic      predBackup,
  output logic      regCopy,
  output logic      memRestore,
  output logic      done
);

  phase_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    strobe    = '0;
    unique case (state)
      ST_IDLE: begin
        strobe.recordEn = 1'b1;
        if (mismatch) begin
          strobe.capture = 1'b1;
          nextState      = ST_FLUSH;
        end
      end
      ST_FLUSH: nextState = ST_PC;
      ST_PC:    nextState = ST_PRED;
      ST_PRED: begin
        strobe.idxClear = 1'b1;
        nextState       = ST_REGS;
      end
      ST_REGS: begin
        if (regLast) begin
          strobe.idxClear = 1'b1;
          nextState       = memNone ? ST_DONE : ST_MEM;
        end else begin
          strobe.idxStep = 1'b1;
        end
      end
      ST_MEM: begin
        if (memLast) nextState = ST_DONE;
        else         strobe.idxStep = 1'b1;
      end
      ST_DONE: begin
        strobe.tableClear = 1'b1;
        nextState         = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign busy       = (state != ST_IDLE);
  assign dbFlush    = (state == ST_FLUSH);
  assign pcLoad     = (state == ST_PC);
  assign predBackup = (state == ST_PRED);
  assign regCopy    = (state == ST_REGS);
  assign memRestore = (state == ST_MEM);
  assign done       = (state == ST_DONE);

  // R8: never two step strobes at once
  a_r8_one_step: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({dbFlush, pcLoad, predBackup, regCopy, memRestore, done}));

  // R2: step order flush -> PC -> predictor
  a_r2_flush_first: assert property (@(posedge clk) disable iff (!rstN)
    !busy && mismatch |=> dbFlush);
  a_r2_pc_after_flush: assert property (@(posedge clk) disable iff (!rstN)
    dbFlush |=> pcLoad);
  a_r2_pred_after_pc: assert property (@(posedge clk) disable iff (!rstN)
    pcLoad |=> predBackup);

  // R8 / R10: done returns to idle, no re-trigger mid-sequence
  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy);
  a_r10_no_restart: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> !dbFlush);

endmodule

// File: rtl/slip_recovery.sv
module slip_recovery
  import rc_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int PC_W        = 32,
  parameter int NUM_REGS    = 32,
  parameter int TABLE_DEPTH = 16
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        storeValid,
  input  logic [ADDR_W-1:0]           storeAddr,
  input  logic                        mismatch,
  input  logic [PC_W-1:0]             trailPc,
  output logic                        busy,
  output logic                        dbFlush,
  output logic                        pcLoad,
  output logic                        predBackup,
  output logic [PC_W-1:0]             pcValue,
  output logic                        regCopy,
  output logic [$clog2(NUM_REGS)-1:0] regIdx,
  output logic                        memRestore,
  output logic [ADDR_W-1:0]           memAddr,
  output logic                        done
);

  dpStrobe_t strobe;
  logic      regLast;
  logic      memLast;
  logic      memNone;

  rc_ctrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .mismatch  (mismatch),
    .regLast   (regLast),
    .memLast   (memLast),
    .memNone   (memNone),
    .strobe    (strobe),
    .busy      (busy),
    .dbFlush   (dbFlush),
    .pcLoad    (pcLoad),
    .predBackup(predBackup),
    .regCopy   (regCopy),
    .memRestore(memRestore),
    .done      (done)
  );

  rc_datapath #(
    .ADDR_W     (ADDR_W),
    .PC_W       (PC_W),
    .NUM_REGS   (NUM_REGS),
    .TABLE_DEPTH(TABLE_DEPTH)
  ) uPath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .storeValid(storeValid),
    .storeAddr (storeAddr),
    .trailPc   (trailPc),
    .pcHeld    (pcValue),
    .regIdx    (regIdx),
    .memAddr   (memAddr),
    .regLast   (regLast),
    .memLast   (memLast),
    .memNone   (memNone)
  );

  // R3: the register run starts at index 0 and climbs by one
  a_r3_first_reg: assert property (@(posedge clk) disable iff (!rstN)
    $rose(regCopy) |-> (regIdx == '0));
  a_r3_reg_climb: assert property (@(posedge clk) disable iff (!rstN)
    regCopy && $past(regCopy) |-> (regIdx == $past(regIdx) + 1'b1));

  // R2: the held PC does not move while the sequence runs
  a_r2_pc_held: assert property (@(posedge clk) disable iff (!rstN)
    busy && $past(busy) |-> $stable(pcValue));

endmodule

// File: tb/slip_recovery_test.sv
`timescale 1ns/1ps
module slip_recovery_test;

  logic        clk = 1'b0;
  logic        rstN;
  logic        storeValid;
  logic [7:0]  storeAddr;
  logic        mismatch;
  logic [31:0] trailPc;
  logic        busy, dbFlush, pcLoad, predBackup, regCopy, memRestore, done;
  logic [31:0] pcValue;
  logic [4:0]  regIdx;
  logic [7:0]  memAddr;

  always #2 clk = ~clk;

  slip_recovery uut (
    .clk(clk), .rstN(rstN), .storeValid(storeValid), .storeAddr(storeAddr),
    .mismatch(mismatch), .trailPc(trailPc), .busy(busy), .dbFlush(dbFlush),
    .pcLoad(pcLoad), .predBackup(predBackup), .pcValue(pcValue),
    .regCopy(regCopy), .regIdx(regIdx), .memRestore(memRestore),
    .memAddr(memAddr), .done(done)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  int tab[$];
  bit ovf = 0;

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit inTab(int a);
    foreach (tab[i]) if (tab[i] == a) return 1'b1;
    return 1'b0;
  endfunction

  function automatic void modelStore(int a);
    if (!inTab(a)) begin
      if (tab.size() < 16) tab.push_back(a);
      else ovf = 1'b1;
    end
  endfunction

  task automatic doStore(int a);
    storeValid = 1'b1;
    storeAddr  = 8'(a);
    @(negedge clk);
    storeValid = 1'b0;
    modelStore(a);
  endtask

  // kinds: 1 flush, 2 pc, 3 pred, 4 reg, 5 mem, 6 done
  task automatic recover(logic [31:0] pc, bit sameStore, int sAddr, bit noise, string tag);
    int kinds[$];
    int vals[$];
    mismatch = 1'b1;
    trailPc  = pc;
    if (sameStore) begin
      storeValid = 1'b1;
      storeAddr  = 8'(sAddr);
      modelStore(sAddr);
    end
    kinds.push_back(1); vals.push_back(0);
    kinds.push_back(2); vals.push_back(0);
    kinds.push_back(3); vals.push_back(0);
    for (int r = 0; r < 32; r++) begin kinds.push_back(4); vals.push_back(r); end
    if (ovf) begin
      for (int m = 0; m < 256; m++) begin kinds.push_back(5); vals.push_back(m); end
    end else begin
      foreach (tab[i]) begin kinds.push_back(5); vals.push_back(tab[i]); end
    end
    kinds.push_back(6); vals.push_back(0);
    @(negedge clk);
    mismatch   = 1'b0;
    storeValid = 1'b0;
    trailPc    = $urandom;
    for (int k = 0; k < kinds.size(); k++) begin
      logic [5:0] act, exp;
      string req;
      bit valOk;
      act = {dbFlush, pcLoad, predBackup, regCopy, memRestore, done};
      exp = 6'b100000 >> (kinds[k] - 1);
      case (kinds[k])
        1, 2, 3: req = "R2";
        4:       req = "R3";
        5:       req = ovf ? "R7" : "R4";
        default: req = "R8";
      endcase
      valOk = 1'b1;
      if (kinds[k] == 2 || kinds[k] == 3) valOk = (pcValue == pc);
      if (kinds[k] == 4) valOk = (regIdx == 5'(vals[k]));
      if (kinds[k] == 5) valOk = (memAddr == 8'(vals[k]));
      check(act == exp && busy, {req, "(", tag, ")"}, $sformatf("step %0d strobes", k),
            {busy, act}, {1'b1, exp});
      if (!valOk) begin
        check(1'b0, {req, "(", tag, ")"}, $sformatf("step %0d value", k),
              kinds[k] == 4 ? longint'(regIdx) : kinds[k] == 5 ? longint'(memAddr) : longint'(pcValue),
              kinds[k] == 2 || kinds[k] == 3 ? longint'(pc) : longint'(vals[k]));
      end
      if (noise) begin
        mismatch   = 1'($urandom_range(0, 1));
        storeValid = 1'($urandom_range(0, 1));
        storeAddr  = 8'($urandom_range(0, 255));
      end
      @(negedge clk);
    end
    mismatch   = 1'b0;
    storeValid = 1'b0;
    check(!busy && {dbFlush, pcLoad, predBackup, regCopy, memRestore, done} == 6'b0,
          {"R8/R10(", tag, ")"}, "idle after done",
          {busy, dbFlush, pcLoad, predBackup, regCopy, memRestore, done}, 0);
    tab.delete();
    ovf = 1'b0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : stimulus
    void'($urandom(32'd2718));
    rstN = 1'b0; storeValid = 1'b0; storeAddr = '0; mismatch = 1'b0; trailPc = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check({busy, dbFlush, pcLoad, predBackup, regCopy, memRestore, done} == 7'b0,
          "R1", "reset outputs", {busy, dbFlush, pcLoad, predBackup, regCopy, memRestore, done}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !done, "R1", "idle after reset", {busy, done}, 0);

    // R6: empty table
    recover(32'h0000_1000, 1'b0, 0, 1'b0, "R6 empty");

    // R4, R5: in-order restore with repeats
    doStore(10); doStore(20); doStore(10); doStore(5); doStore(20); doStore(7);
    recover(32'h0000_2040, 1'b0, 0, 1'b0, "R4 R5 dedup");

    // R11: store in the trigger cycle, R10: noise while busy
    doStore(33); doStore(44);
    recover(32'hDEAD_BEE0, 1'b1, 99, 1'b1, "R11 R10 same-cycle");

    // R9: table emptied by the last pass
    recover(32'h0000_3000, 1'b0, 0, 1'b0, "R9 cleared");

    // R7: exactly full table still tracked, then one more overflows
    for (int a = 0; a < 16; a++) doStore(100 + a);
    doStore(100);
    recover(32'h0000_4000, 1'b0, 0, 1'b0, "R7 full no overflow");
    for (int a = 0; a < 17; a++) doStore(200 - 3 * a);
    recover(32'h0000_5000, 1'b0, 0, 1'b1, "R7 overflow");
    recover(32'h0000_6000, 1'b0, 0, 1'b0, "R9 overflow cleared");

    // R4 R5 R10 R11: random rounds
    for (int round = 0; round < 12; round++) begin
      int n;
      n = $urandom_range(0, 20);
      for (int s = 0; s < n; s++) doStore($urandom_range(0, 31));
      repeat ($urandom_range(0, 2)) @(negedge clk);
      recover($urandom, 1'($urandom_range(0, 1)), $urandom_range(0, 31), 1'b1, "R4 R10 random");
    end

    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule